// File: doc/BRIEF.md
# MDIO Link-Status Poller

This block is the management-side master of a Clause 22 MDIO link to an external Ethernet PHY. It generates the management clock from the system clock and serialises complete management frames onto a single data line that has an output-enable. It releases that line during the turnaround and data phases of a read and samples the bits the PHY returns. The PHY address in every frame is fixed at 1.

A poll timer reads the PHY's vendor-specific auto-negotiation result register at a programmable interval. The register number is 16 plus a 4-bit offset. Two 4-bit position fields pick the duplex flag and the speed flag out of the returned 16-bit word, and each flag can be complemented on its own. The block latches the two flags as the link status and raises a one-cycle pulse whenever either of them changes.

A host can request one register read or write at a time. A pending host request is served before a due poll. A frame that has already started always runs to its end.

Top module: `mdio_link_poller`

## Requirements
- R1: Every frame starts with 32 driven ones on `mdio_o` (`mdio_oe`=1), one per `mdc` period, then the start pattern 0, 1. A frame is 64 `mdc` periods long.
- R2: After the start pattern come the opcode (read = 1,0; write = 0,1), the PHY address 00001 and the 5-bit register number, all MSB first.
- R3: A write frame drives turnaround bits 1 then 0, then the 16 bits of `host_wdata` MSB first, with `mdio_oe` high for all 64 bits.
- R4: A read frame releases the line (`mdio_oe`=0) from the first turnaround bit to the end of the frame. It takes the 16 data bits MSB first from `mdio_i` on the `mdc` rising edges of bit periods 48 to 63, and presents them on `host_rdata` for host reads.
- R5: Each `mdc` half period lasts `mdc_half`+1 clock cycles. `mdio_o` and `mdio_oe` change only while `mdc` is low. When idle, `mdc` is low and `mdio_oe` is 0.
- R6: `busy` rises with the first preamble bit and falls when the last bit period ends. `host_done` pulses in that same cycle for host frames only.
- R7: With `poll_period` P nonzero, a read of register 16+`res_offset` becomes due every P cycles. Back-to-back polls with no host frame between them start exactly P cycles apart. P = 0 stops polling.
- R8: A pending host request is launched before a due poll, and a frame in progress is never cut short.
- R9: After a poll read of word W ends, `link_full` = W[`dup_bit`] XOR `dup_invert` and `link_fast` = W[`spd_bit`] XOR `spd_invert`, visible one cycle after `busy` falls. Neither changes at any other time, including after host reads of the same register.
- R10: `status_chg` is a one-cycle pulse, in the cycle the new status appears, only when `link_full` or `link_fast` differs from its previous value.
- R11: After reset, `mdc`, `mdio_oe`, `busy`, `host_done`, `link_fast`, `link_full` and `status_chg` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mdc_half | input | DIV_W | Clock cycles per `mdc` half period, minus one |
| poll_period | input | POLL_W | Poll interval in cycles; 0 disables polling |
| res_offset | input | 4 | Result register number minus 16 |
| dup_bit | input | 4 | Bit position of the duplex flag |
| spd_bit | input | 4 | Bit position of the speed flag |
| dup_invert | input | 1 | Complement the duplex flag |
| spd_invert | input | 1 | Complement the speed flag |
| host_req | input | 1 | One-cycle host request, taken when no host request is pending |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_reg | input | 5 | Host register number |
| host_wdata | input | 16 | Host write data |
| host_done | output | 1 | Host frame finished (pulse) |
| host_rdata | output | 16 | Data of the last read frame |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |
| busy | output | 1 | Frame in progress |
| link_fast | output | 1 | Latched speed flag (1 = 100) |
| link_full | output | 1 | Latched duplex flag (1 = full) |
| status_chg | output | 1 | Link status changed (pulse) |

## Verification
The bench goes after the turnaround bits. A design that drove the line there on reads, or swapped 1 and 0 there on writes, would show up in the per-bit comparison of each frame. It uses the extreme bit positions 0 and 15, inverted flags, and more than one result register. An off-by-one in extraction or in the register number would latch the wrong status. It repeats a poll with an unchanged word to catch a status pulse raised on every update. It issues a host read of the result register to catch a design that lets host reads overwrite the status. It places a host request in the middle of a poll, where a design that interrupted the frame or served the poll first would break the expected frame order. It also times poll spacing and `mdc` half periods against the programmed values.

// File: rtl/mdpoll_pkg.sv
package mdpoll_pkg;

   localparam int         FRAME_BITS = 64;
   localparam int         PRE_BITS   = 32;
   localparam int         TA_FIRST   = 46;
   localparam int         DATA_FIRST = 48;
   localparam int         WORD_W     = 16;
   localparam int         POS_W      = $clog2(WORD_W);
   localparam logic [4:0] PHY_ADDR   = 5'd1;

   typedef struct packed {
      logic              wr;
      logic [4:0]        regad;
      logic [WORD_W-1:0] wdata;
   } mdio_cmd_t;

   typedef struct packed {
      logic [POS_W-1:0] dup_pos;
      logic [POS_W-1:0] spd_pos;
      logic             dup_inv;
      logic             spd_inv;
   } extract_cfg_t;

   // Frame image, first bit on the wire at the MSB.
   function automatic logic [FRAME_BITS-1:0] frame_bits(mdio_cmd_t c);
      logic [1:0] op;
      logic [1:0] ta;
      op = c.wr ? 2'b01 : 2'b10;
      ta = c.wr ? 2'b10 : 2'b00;
      return {{PRE_BITS{1'b1}}, 2'b01, op, PHY_ADDR, c.regad, ta,
              (c.wr ? c.wdata : {WORD_W{1'b0}})};
   endfunction

   // Output-enable image: writes drive every bit, reads stop at turnaround.
   function automatic logic [FRAME_BITS-1:0] drive_mask(logic wr);
      return wr ? {FRAME_BITS{1'b1}}
                : {{TA_FIRST{1'b1}}, {(FRAME_BITS-TA_FIRST){1'b0}}};
   endfunction

endpackage

// File: rtl/mdpoll_clkdiv.sv
module mdpoll_clkdiv #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half_cnt,
   output logic             tick
);

   if (DIV_W < 1) begin : g_bad_div
      $error("mdpoll_clkdiv: DIV_W must be at least 1");
   end

   logic [DIV_W-1:0] cnt;

   assign tick = run && (cnt == half_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || tick)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/mdpoll_frame.sv
module mdpoll_frame
   import mdpoll_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  mdio_cmd_t         cmd,
   input  logic              tick,
   input  logic              mdio_i,
   output logic              busy,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic              done,
   output logic [WORD_W-1:0] rdata
);

   localparam int IDX_W = $clog2(FRAME_BITS);

   if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
      $error("mdpoll_frame: SYNC_STAGES must be 0..3");
   end

   logic                  din;
   logic [FRAME_BITS-1:0] sh;
   logic [FRAME_BITS-1:0] om;
   logic [IDX_W-1:0]      idx;
   logic                  wr_q;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign din = mdio_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] ff;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ff <= '1;
         else begin
            ff[0] <= mdio_i;
            for (int k = 1; k < SYNC_STAGES; k++)
               ff[k] <= ff[k-1];
         end
      end
      assign din = ff[SYNC_STAGES-1];
   end

   assign mdio_o  = sh[FRAME_BITS-1];
   assign mdio_oe = om[FRAME_BITS-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         mdc   <= 1'b0;
         done  <= 1'b0;
         sh    <= '0;
         om    <= '0;
         idx   <= '0;
         wr_q  <= 1'b0;
         rdata <= '0;
      end else begin
         done <= 1'b0;
         if (start && !busy) begin
            busy <= 1'b1;
            mdc  <= 1'b0;
            idx  <= '0;
            sh   <= frame_bits(cmd);
            om   <= drive_mask(cmd.wr);
            wr_q <= cmd.wr;
         end else if (busy && tick) begin
            if (!mdc) begin
               mdc <= 1'b1;
               if (!wr_q && idx >= IDX_W'(DATA_FIRST))
                  rdata <= {rdata[WORD_W-2:0], din};
            end else begin
               mdc <= 1'b0;
               if (idx == IDX_W'(FRAME_BITS-1)) begin
                  busy <= 1'b0;
                  done <= 1'b1;
                  om   <= '0;
               end else begin
                  idx <= idx + 1'b1;
                  sh  <= sh << 1;
                  om  <= om << 1;
               end
            end
         end
      end
   end

   AST_PREAMBLE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && idx < IDX_W'(PRE_BITS)) |-> (mdio_oe && mdio_o)); // R1
   AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_q) |-> mdio_oe); // R3
   AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !wr_q && idx >= IDX_W'(TA_FIRST)) |-> !mdio_oe); // R4
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdio_oe && !mdc)); // R5
   AST_MDIO_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      mdc |-> ($stable(mdio_o) && $stable(mdio_oe))); // R5
   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) && !busy)); // R6

endmodule

// File: rtl/mdpoll_status.sv
module mdpoll_status
   import mdpoll_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd,
   input  logic [WORD_W-1:0] word,
   input  extract_cfg_t      cfg,
   output logic              link_fast,
   output logic              link_full,
   output logic              chg
);

   logic nxt_fast;
   logic nxt_full;

   always_comb begin
      nxt_fast = word[cfg.spd_pos] ^ cfg.spd_inv;
      nxt_full = word[cfg.dup_pos] ^ cfg.dup_inv;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         link_fast <= 1'b0;
         link_full <= 1'b0;
         chg       <= 1'b0;
      end else begin
         chg <= 1'b0;
         if (upd) begin
            link_fast <= nxt_fast;
            link_full <= nxt_full;
            chg       <= (nxt_fast != link_fast) || (nxt_full != link_full);
         end
      end
   end

   AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> ($stable(link_fast) && $stable(link_full))); // R9
   AST_CHG_MEANS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      chg |-> ((link_fast != $past(link_fast)) || (link_full != $past(link_full)))); // R10

endmodule

// File: rtl/mdio_link_poller.sv
module mdio_link_poller
   import mdpoll_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int POLL_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  mdc_half,
   input  logic [POLL_W-1:0] poll_period,
   input  logic [3:0]        res_offset,
   input  logic [3:0]        dup_bit,
   input  logic [3:0]        spd_bit,
   input  logic              dup_invert,
   input  logic              spd_invert,
   input  logic              host_req,
   input  logic              host_wr,
   input  logic [4:0]        host_reg,
   input  logic [15:0]       host_wdata,
   output logic              host_done,
   output logic [15:0]       host_rdata,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i,
   output logic              busy,
   output logic              link_fast,
   output logic              link_full,
   output logic              status_chg
);

   if (POLL_W < 2) begin : g_bad_poll
      $error("mdio_link_poller: POLL_W must be at least 2");
   end

   logic              eng_busy;
   logic              eng_done;
   logic              tick;
   logic [15:0]       eng_rdata;
   logic              host_pend;
   mdio_cmd_t         host_cmd;
   mdio_cmd_t         launch_cmd;
   logic              poll_due;
   logic [POLL_W-1:0] ptmr;
   logic              cur_poll;
   logic              launch;
   logic              poll_on;
   extract_cfg_t      xcfg;

   assign poll_on = (poll_period != '0);
   assign launch  = !eng_busy && (host_pend || (poll_due && poll_on));

   always_comb begin
      launch_cmd.wr    = 1'b0;
      launch_cmd.regad = {1'b1, res_offset};
      launch_cmd.wdata = '0;
      if (host_pend)
         launch_cmd = host_cmd;
      xcfg.dup_pos = dup_bit;
      xcfg.spd_pos = spd_bit;
      xcfg.dup_inv = dup_invert;
      xcfg.spd_inv = spd_invert;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_pend <= 1'b0;
         host_cmd  <= '0;
         cur_poll  <= 1'b0;
         poll_due  <= 1'b0;
         ptmr      <= '0;
      end else begin
         if (host_req && !host_pend) begin
            host_pend      <= 1'b1;
            host_cmd.wr    <= host_wr;
            host_cmd.regad <= host_reg;
            host_cmd.wdata <= host_wdata;
         end
         if (launch && host_pend) begin
            host_pend <= 1'b0;
            cur_poll  <= 1'b0;
         end else if (launch) begin
            cur_poll <= 1'b1;
            poll_due <= 1'b0;
         end
         if (!poll_on) begin
            ptmr     <= '0;
            poll_due <= 1'b0;
         end else if (ptmr >= poll_period - 1'b1) begin
            ptmr     <= '0;
            poll_due <= 1'b1;
         end else begin
            ptmr <= ptmr + 1'b1;
         end
      end
   end

   mdpoll_clkdiv #(.DIV_W(DIV_W)) i_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (eng_busy),
      .half_cnt (mdc_half),
      .tick     (tick)
   );

   mdpoll_frame #(.SYNC_STAGES(SYNC_STAGES)) i_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (launch),
      .cmd     (launch_cmd),
      .tick    (tick),
      .mdio_i  (mdio_i),
      .busy    (eng_busy),
      .mdc     (mdc),
      .mdio_o  (mdio_o),
      .mdio_oe (mdio_oe),
      .done    (eng_done),
      .rdata   (eng_rdata)
   );

   mdpoll_status i_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd       (eng_done && cur_poll),
      .word      (eng_rdata),
      .cfg       (xcfg),
      .link_fast (link_fast),
      .link_full (link_full),
      .chg       (status_chg)
   );

   assign busy       = eng_busy;
   assign host_done  = eng_done && !cur_poll;
   assign host_rdata = eng_rdata;

   AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_busy && $past(eng_busy)) |-> $stable(cur_poll)); // R8
   AST_HOST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (launch && host_pend) |=> (eng_busy && !cur_poll)); // R8

endmodule

// File: tb/test_mdio_link_poller.sv
`timescale 1ns/1ps
module test_mdio_link_poller;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  mdc_half = 8'd3;
   logic [15:0] poll_period = '0;
   logic [3:0]  res_offset = 4'd1, dup_bit = 4'd13, spd_bit = 4'd14;
   logic        dup_invert = 1'b0, spd_invert = 1'b0;
   logic        host_req = 1'b0, host_wr = 1'b0;
   logic [4:0]  host_reg = '0;
   logic [15:0] host_wdata = '0;
   logic        host_done, mdc, mdio_o, mdio_oe, mdio_i, busy;
   logic        link_fast, link_full, status_chg;
   logic [15:0] host_rdata;
   logic        phy_en = 1'b0, phy_val = 1'b1;

   always #2 clk = ~clk;

   assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_val : 1'b1);

   mdio_link_poller i_mdio_link_poller (
      .clk(clk), .rst_n(rst_n), .mdc_half(mdc_half), .poll_period(poll_period),
      .res_offset(res_offset), .dup_bit(dup_bit), .spd_bit(spd_bit),
      .dup_invert(dup_invert), .spd_invert(spd_invert),
      .host_req(host_req), .host_wr(host_wr), .host_reg(host_reg),
      .host_wdata(host_wdata), .host_done(host_done), .host_rdata(host_rdata),
      .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i),
      .busy(busy), .link_fast(link_fast), .link_full(link_full),
      .status_chg(status_chg)
   );

   int checks = 0, errors = 0;
   bit finished = 0;

   logic [15:0] phy_regs [32];

   // bench reference state
   bit          b_host_pend = 0;
   bit          b_host_wr;
   logic [4:0]  b_host_reg;
   logic [15:0] b_host_wd;
   int          exp_q [$];
   bit          cur_host, cur_wr;
   logic [4:0]  cur_reg;
   int          rises = 0, hcnt = 0, cyc = 0, last_poll = -1, poll_cnt = 0;
   bit          prev_mdc = 0, prev_busy = 0;
   bit          upd_pend = 0, new_fast = 0, new_full = 0, new_chg = 0;
   bit          vis_fast = 0, vis_full = 0, chg_exp;

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic void push_frame(bit wr, logic [4:0] rg, logic [15:0] d);
      for (int i = 0; i < 32; i++) exp_q.push_back(1);
      exp_q.push_back(0); exp_q.push_back(1);
      if (wr) begin exp_q.push_back(0); exp_q.push_back(1); end
      else    begin exp_q.push_back(1); exp_q.push_back(0); end
      for (int i = 4; i >= 0; i--) exp_q.push_back(int'(i == 0));
      for (int i = 4; i >= 0; i--) exp_q.push_back(int'(rg[i]));
      if (wr) begin exp_q.push_back(1); exp_q.push_back(0); end
      else    begin exp_q.push_back(2); exp_q.push_back(2); end
      for (int i = 15; i >= 0; i--) exp_q.push_back(wr ? int'(d[i]) : 2);
   endfunction

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         cyc++;
         // status outputs, compared on every clock
         if (upd_pend) begin
            vis_fast = new_fast; vis_full = new_full; chg_exp = new_chg; upd_pend = 0;
         end else chg_exp = 0;
         chk(status_chg == chg_exp, "R10", "status_chg", status_chg, chg_exp);
         chk(link_fast == vis_fast, "R9", "link_fast", link_fast, vis_fast);
         chk(link_full == vis_full, "R9", "link_full", link_full, vis_full);
         if (!busy) chk(!mdc && !mdio_oe, "R5", "idle mdc/oe", {mdc, mdio_oe}, 0);

         // frame start
         if (busy && !prev_busy) begin
            if (b_host_pend) begin
               cur_host = 1; cur_wr = b_host_wr; cur_reg = b_host_reg;
               b_host_pend = 0; last_poll = -1;
               push_frame(cur_wr, cur_reg, b_host_wd);
            end else begin
               cur_host = 0; cur_wr = 0; cur_reg = {1'b1, res_offset};
               chk(poll_period != 0, "R7", "poll while disabled", 1, 0);
               if (last_poll >= 0)
                  chk(cyc - last_poll == int'(poll_period), "R7", "poll spacing",
                      cyc - last_poll, poll_period);
               last_poll = cyc;
               push_frame(0, cur_reg, 16'h0);
            end
            rises = 0; hcnt = 0;
         end else if (prev_busy) hcnt++;

         if (mdc != prev_mdc) begin
            chk(hcnt == int'(mdc_half) + 1, "R5", "mdc half period", hcnt, mdc_half + 1);
            hcnt = 0;
         end

         if (mdc && !prev_mdc) begin
            int obs, ex;
            obs = mdio_oe ? int'(mdio_o) : 2;
            ex = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
            if (rises < 34)      chk(obs == ex, "R1", "preamble/start bit", obs, ex);
            else if (rises < 46) chk(obs == ex, "R2", "op/addr bit", obs, ex);
            else if (cur_wr)     chk(obs == ex, "R3", "write ta/data bit", obs, ex);
            else                 chk(obs == ex, "R4", "read ta/data bit", obs, ex);
            rises++;
         end

         if (!mdc && prev_mdc) begin
            if (!cur_wr && rises == 47) begin phy_en = 1; phy_val = 0; end
            else if (!cur_wr && rises >= 48 && rises <= 63) begin
               phy_en = 1; phy_val = phy_regs[cur_reg][63-rises];
            end else phy_en = 0;
         end

         if (!busy && prev_busy) begin
            chk(rises == 64, "R1", "bits per frame", rises, 64);
            chk(exp_q.size() == 0, "R6", "frame ended early", exp_q.size(), 0);
            if (cur_host) begin
               chk(host_done == 1, "R6", "host_done at end", host_done, 1);
               if (!cur_wr)
                  chk(host_rdata == phy_regs[cur_reg], "R4", "host_rdata",
                      host_rdata, phy_regs[cur_reg]);
            end else begin
               logic [15:0] w;
               w = phy_regs[cur_reg];
               chk(host_done == 0, "R6", "host_done on poll", host_done, 0);
               new_fast = w[spd_bit] ^ spd_invert;
               new_full = w[dup_bit] ^ dup_invert;
               new_chg  = (new_fast != vis_fast) || (new_full != vis_full);
               upd_pend = 1;
               poll_cnt++;
            end
            exp_q.delete();
         end else begin
            chk(host_done == 0, "R6", "stray host_done", host_done, 0);
         end
         prev_mdc = mdc; prev_busy = busy;
      end
   end

   task automatic host_op(bit wr, logic [4:0] rg, logic [15:0] d);
      @(negedge clk);
      host_req = 1; host_wr = wr; host_reg = rg; host_wdata = d;
      b_host_pend = 1; b_host_wr = wr; b_host_reg = rg; b_host_wd = d;
      @(negedge clk);
      host_req = 0;
      while (!host_done) @(negedge clk);
   endtask

   task automatic wait_idle();
      int q;
      q = 0;
      while (q < 4) begin
         @(negedge clk);
         q = busy ? 0 : q + 1;
      end
   endtask

   task automatic set_period(logic [15:0] p);
      @(negedge clk);
      poll_period = p; last_poll = -1;
      if (p == 0) wait_idle();
   endtask

   task automatic wait_polls(int n);
      int target;
      target = poll_cnt + n;
      while (poll_cnt < target) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < 32; i++) phy_regs[i] = 16'(i * 16'h0931) ^ 16'h5A3C;
      phy_regs[2] = 16'h1234;
      phy_regs[17] = 16'h6000;
      phy_regs[25] = 16'h0001;
      repeat (3) @(negedge clk);
      chk(!mdc && !mdio_oe && !busy && !host_done, "R11", "reset outputs",
          {mdc, mdio_oe, busy, host_done}, 0);
      chk(!link_fast && !link_full && !status_chg, "R11", "reset status",
          {link_fast, link_full, status_chg}, 0);
      rst_n = 1;
      repeat (5) @(negedge clk);

      host_op(1, 5'd4, 16'hA5C3);       // R3 write frame
      host_op(0, 5'd2, 16'h0);          // R4 read frame
      host_op(1, 5'd31, 16'h8001);      // R2 top register number
      host_op(0, 5'd0, 16'h0);          // R2 register 0

      set_period(16'd1500);             // R7, R9: bits 13 and 14 of reg 17
      wait_polls(1);
      chk(link_fast && link_full, "R9", "status after poll", {link_fast, link_full}, 3);
      wait_polls(1);                    // R10: same word, no pulse
      set_period(16'd0);

      @(negedge clk) dup_invert = 1;    // R9 inversion
      set_period(16'd1500);
      wait_polls(1);
      chk(!link_full && link_fast, "R9", "inverted duplex", {link_fast, link_full}, 2);

      while (!busy) @(negedge clk);     // R8: host request during a poll
      repeat (20) @(negedge clk);
      host_op(0, 5'd3, 16'h0);
      wait_polls(1);
      set_period(16'd0);

      @(negedge clk);                   // reg 25, edge bit positions
      mdc_half = 8'd2; res_offset = 4'd9; dup_bit = 4'd0; spd_bit = 4'd15;
      dup_invert = 0; spd_invert = 0;
      set_period(16'd900);
      wait_polls(2);
      chk(link_full && !link_fast, "R9", "reg 25 status", {link_fast, link_full}, 1);
      set_period(16'd0);

      phy_regs[25] = 16'h8000;          // R9: host read must not touch status
      host_op(0, 5'd25, 16'h0);
      repeat (4) @(negedge clk);
      chk(link_full && !link_fast, "R9", "status after host read",
          {link_fast, link_full}, 1);
      set_period(16'd700);
      wait_polls(1);
      chk(!link_full && link_fast, "R10", "status after new poll",
          {link_fast, link_full}, 2);
      set_period(16'd0);

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; errors++;
         $display("FAIL watchdog run did not finish actual=0 expected=1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule